// File: doc/BRIEF.md
# Dual-Channel Timer Output Compare

This block is a 16-bit free-running up-counter with two output compare channels, programmed through a small byte-wide register bus. A two-bit clock-select field decides what advances the counter: the system clock divided by 2, 4 or 8, or rising edges of an external clock input, which is first brought into the system clock domain. The counter starts at zero after reset, advances by one on each tick and wraps from FFFFh to 0000h.

Each channel holds a 16-bit compare value, written and read as separate high and low bytes. When the counter steps onto a channel's compare value, the channel sets its status flag and, if its pin drive is enabled, copies its programmed level onto its output pin. A single interrupt line is raised while any flag is set, the interrupt enable is on and the external mask is clear. Writing a high byte holds that channel's compares off until the matching low byte arrives, so a 16-bit value is never compared half-written. A flag clears only after software reads the status register while the flag is set and then touches that channel's low byte.

Top module: `dual_oc_timer`

Register map (4-bit address, 8-bit data): 0 = CFG_A (bit 0 level of channel 1, bit 1 level of channel 2, bit 2 interrupt enable); 1 = CFG_B (bits 1:0 clock select, bit 2 pin enable of channel 1, bit 3 pin enable of channel 2); 2 = STAT, read-only (bit 0 flag of channel 1, bit 1 flag of channel 2); 3/4 = channel 1 compare high/low; 5/6 = channel 2 compare high/low; 7/8 = counter high/low, read-only. Reads return data combinationally from the address; the read strobe only matters for the flag handshake.

## Requirements
- R1: After reset both compare registers read 80h (high) and 00h (low), STAT, CFG_A and CFG_B read 00h, both pins are low and the interrupt is low.
- R2: Each compare byte reads back the last value written to it, and no timer activity changes it.
- R3: Clock select 00, 01 and 10 advance the counter once every 2, 4 and 8 system clocks; the counter reads back at addresses 7 (high) and 8 (low).
- R4: With clock select 11 the counter advances exactly once per rising edge of the external clock input, after a two-flop synchroniser.
- R5: A channel's STAT flag is set on the clock edge at which the counter takes that channel's compare value, and not before.
- R6: On a match, a channel's pin takes its level bit only when its pin enable is set; otherwise the pin keeps its value.
- R7: The interrupt output is high exactly when the interrupt enable is set, the mask input is low and at least one flag is set.
- R8: A flag clears on a low-byte read or write of its channel only if a STAT read was made while that flag was set; a low-byte access alone or a STAT read alone leaves it set.
- R9: Writing a channel's high compare byte stops that channel from matching until its low byte is written.
- R10: When a match and a flag clear fall in the same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ext_clk | input | 1 | External timer clock, asynchronous |
| irq_mask | input | 1 | Global interrupt mask, high blocks the interrupt |
| cmp_pin | output | 2 | Compare output pins, bit 0 for channel 1 |
| irq | output | 1 | Compare interrupt request |

## Verification
The bench drives the counter from the external clock so that each match lands on a known edge, and checks that the flag appears when the counter reaches the compare value rather than one tick later; a design that compared the old count would set the flag one tick late. It walks the clear handshake in its broken orders, where a design that cleared on a low-byte access alone or on a status read alone would drop the flag too early. It lines up a match with the clearing low-byte read, where a design that let the clear win would lose the event. It also leaves a high byte written alone with the low byte already matching, where a design without the compare hold would fire on a half-updated value.

// File: rtl/oc_pkg.sv
// Package: shared register addresses and clock-select codes for the
// dual output compare timer. Assumes a 4-bit byte-wide register bus.
package oc_pkg;

    localparam int ADR_CFG_A = 0;
    localparam int ADR_CFG_B = 1;
    localparam int ADR_STAT  = 2;
    localparam int ADR_CMP0H = 3;   // channel i high byte at ADR_CMP0H + 2*i
    localparam int ADR_CNT_H = 7;
    localparam int ADR_CNT_L = 8;

    typedef enum logic [1:0] {
        CSEL_DIV2 = 2'b00,
        CSEL_DIV4 = 2'b01,
        CSEL_DIV8 = 2'b10,
        CSEL_EXT  = 2'b11
    } csel_t;

endpackage

// File: rtl/oc_tick_gen.sv
// Tick generator: produces a one-cycle tick enable for the counter, either
// from a free-running prescaler (divide by 2, 4 or 8) or from rising edges of
// an asynchronous external clock brought in through two flops.
// Assumes the external clock is slower than half the system clock.
module oc_tick_gen
    import oc_pkg::*;
#(
    parameter int PRE_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  csel_t      csel,
    input  logic       ext_clk,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic             sync1_q;
    logic             sync2_q;
    logic             edge_q;

    // Free-running prescaler count.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Two-flop synchroniser plus an edge-history flop for the external clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            edge_q  <= 1'b0;
        end else begin
            sync1_q <= ext_clk;
            sync2_q <= sync1_q;
            edge_q  <= sync2_q;
        end
    end

    // Select the tick source from the clock-select field.
    always_comb begin
        unique case (csel)
            CSEL_DIV2: tick = pre_q[0];
            CSEL_DIV4: tick = &pre_q[1:0];
            CSEL_DIV8: tick = &pre_q[2:0];
            default:   tick = sync2_q & ~edge_q;
        endcase
    end

    // R4: an external edge yields a single-cycle tick.
    p_ext_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csel == CSEL_EXT && $past(csel) == CSEL_EXT && tick) |=> !tick);

endmodule

// File: rtl/oc_counter.sv
// Free-running up-counter: advances by one on each tick, wraps at the top,
// and exposes the value it will take on the next tick for the comparators.
module oc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt
);

    // Next count; the width truncation gives the wrap to zero.
    always_comb cnt_nxt = cnt_q + 1'b1;

    // Count register, held between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_nxt;
    end

    // R3: one step per tick, no movement without one.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == W'($past(cnt_q) + 1'b1));
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

endmodule

// File: rtl/oc_channel.sv
// One output compare channel: byte-split compare register, compare hold
// between high and low byte writes, match flag with the two-step clear
// handshake, and the output pin latch. Assumes W is two bytes.
module oc_channel #(
    parameter int          W       = 16,
    parameter logic [15:0] RST_VAL = 16'h8000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt_nxt,
    input  logic         hi_wr,
    input  logic         lo_wr,
    input  logic         lo_acc,
    input  logic         stat_rd,
    input  logic [7:0]   wdata,
    input  logic         pin_en,
    input  logic         level,
    output logic [W-1:0] cmp_q,
    output logic         flag,
    output logic         pin
);

    localparam int HB = W / 2;

    logic inhibit_q;
    logic armed_q;
    logic match;

    // Compare register bytes, changed only by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= W'(RST_VAL);
        end else begin
            if (hi_wr) cmp_q[W-1:HB] <= wdata;
            if (lo_wr) cmp_q[HB-1:0] <= wdata;
        end
    end

    // Compare hold: set by a high-byte write, released by a low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)     inhibit_q <= 1'b0;
        else if (hi_wr) inhibit_q <= 1'b1;
        else if (lo_wr) inhibit_q <= 1'b0;
    end

    // Match when the counter is about to step onto the compare value.
    always_comb match = tick && !inhibit_q && (cnt_nxt == cmp_q);

    // First step of the clear: a status read that saw the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)               armed_q <= 1'b0;
        else if (lo_acc)          armed_q <= 1'b0;
        else if (stat_rd && flag) armed_q <= 1'b1;
    end

    // Match flag; a new match wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (match)              flag <= 1'b1;
        else if (lo_acc && armed_q)  flag <= 1'b0;
    end

    // Output pin latch, updated on a match when the pin is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                pin <= 1'b0;
        else if (match && pin_en)  pin <= level;
    end

    // R9: no flag rise right after a cycle spent inhibited.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_q |=> !$rose(flag));
    // R8: a flag only falls after an armed low-byte access.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(lo_acc) && $past(armed_q)));
    // R2: compare value moves only on bus writes.
    p_cmp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_wr && !lo_wr) |=> $stable(cmp_q));
    // R6: a disabled pin never changes.
    p_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |=> $stable(pin));

endmodule

// File: rtl/dual_oc_timer.sv
// Top of the dual output compare timer: register bus decode, configuration
// registers, read mux, tick generator, counter and the compare channels.
// Assumes single-cycle bus strobes and combinational read data.
module dual_oc_timer
    import oc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 2,
    parameter int PRE_W  = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ext_clk,
    input  logic              irq_mask,
    output logic [NCH-1:0]    cmp_pin,
    output logic              irq
);

    localparam int HB = CNT_W / 2;

    logic [NCH-1:0]   lvl_q;
    logic             irq_en_q;
    csel_t            csel_q;
    logic [NCH-1:0]   pen_q;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [NCH-1:0]   flags;
    logic [CNT_W-1:0] cmp_val [NCH];
    logic             stat_rd;

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= '0;
            irq_en_q <= 1'b0;
            csel_q   <= CSEL_DIV2;
            pen_q    <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(ADR_CFG_A)) begin
                lvl_q    <= bus_wdata[NCH-1:0];
                irq_en_q <= bus_wdata[NCH];
            end
            if (bus_addr == ADDR_W'(ADR_CFG_B)) begin
                csel_q <= csel_t'(bus_wdata[1:0]);
                pen_q  <= bus_wdata[2 +: NCH];
            end
        end
    end

    // Status read strobe for the clear handshake.
    always_comb stat_rd = bus_rd && (bus_addr == ADDR_W'(ADR_STAT));

    oc_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .csel    (csel_q),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    oc_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int AH = ADR_CMP0H + 2 * i;
        logic hi_sel, lo_sel;
        always_comb hi_sel = (bus_addr == ADDR_W'(AH));
        always_comb lo_sel = (bus_addr == ADDR_W'(AH + 1));

        oc_channel #(.W(CNT_W), .RST_VAL(16'h8000)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .cnt_nxt (cnt_nxt),
            .hi_wr   (bus_wr && hi_sel),
            .lo_wr   (bus_wr && lo_sel),
            .lo_acc  ((bus_wr || bus_rd) && lo_sel),
            .stat_rd (stat_rd),
            .wdata   (bus_wdata),
            .pin_en  (pen_q[i]),
            .level   (lvl_q[i]),
            .cmp_q   (cmp_val[i]),
            .flag    (flags[i]),
            .pin     (cmp_pin[i])
        );
    end

    // Combined interrupt request.
    always_comb irq = irq_en_q && !irq_mask && (|flags);

    // Read data mux.
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == ADDR_W'(ADR_CFG_A)) bus_rdata = 8'({irq_en_q, lvl_q});
        if (bus_addr == ADDR_W'(ADR_CFG_B)) bus_rdata = 8'({pen_q, csel_q});
        if (bus_addr == ADDR_W'(ADR_STAT))  bus_rdata = 8'(flags);
        if (bus_addr == ADDR_W'(ADR_CNT_H)) bus_rdata = cnt_q[CNT_W-1:HB];
        if (bus_addr == ADDR_W'(ADR_CNT_L)) bus_rdata = cnt_q[HB-1:0];
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(ADR_CMP0H + 2 * i))     bus_rdata = cmp_val[i][CNT_W-1:HB];
            if (bus_addr == ADDR_W'(ADR_CMP0H + 2 * i + 1)) bus_rdata = cmp_val[i][HB-1:0];
        end
    end

    // R7: the mask always wins over pending flags.
    p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);
    // R7: with enable on and mask off, any flag raises the line.
    p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_q && !irq_mask && flags != '0) |-> irq);

endmodule

// File: tb/dual_oc_timer_tb.sv
module dual_oc_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       irq_mask = 1'b0;
    logic [1:0] cmp_pin;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    dual_oc_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .irq_mask(irq_mask), .cmp_pin(cmp_pin), .irq(irq)
    );

    // Vector: {write, addr[3:0], data[7:0]}; reads compare data.
    localparam int NV = 22;
    localparam logic [12:0] VEC [NV] = '{
        13'h0380, 13'h0400, 13'h0580, 13'h0600, 13'h0200, 13'h0000, 13'h0100,
        13'h1312, 13'h1434, 13'h1556, 13'h1678,
        13'h0312, 13'h0434, 13'h0556, 13'h0678,
        13'h1005, 13'h0005, 13'h110C, 13'h010C, 13'h1000, 13'h1100, 13'h0100
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic peek_cnt(output logic [15:0] c);
        logic [7:0] h, l;
        peek(4'd7, h);
        peek(4'd8, l);
        c = {h, l};
    endtask

    task automatic ext_tick();
        @(negedge clk) ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_cmp(input int ch, input logic [15:0] v);
        bus_write(4'(3 + 2 * ch), v[15:8]);
        bus_write(4'(4 + 2 * ch), v[7:0]);
    endtask

    task automatic div_check(input logic [7:0] sel, input int exp, input string req);
        logic [7:0] a, b;
        bus_write(4'd1, sel);
        peek(4'd8, a);
        repeat (16) @(negedge clk);
        peek(4'd8, b);
        check(8'(b - a) == 8'(exp), req, 8'(b - a), exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0]  d;
        logic [15:0] c, dd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs at reset
        check(cmp_pin == 2'b00, "R1 pins", cmp_pin, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);

        // R1/R2 vector table
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][12]) bus_write(VEC[k][11:8], VEC[k][7:0]);
            else begin
                bus_read(VEC[k][11:8], d);
                check(d == VEC[k][7:0], "R1/R2 register vector", d, VEC[k][7:0]);
            end
        end

        // R3: prescaler rates
        div_check(8'h00, 8, "R3 div2");
        div_check(8'h01, 4, "R3 div4");
        div_check(8'h02, 2, "R3 div8");

        // Switch to external ticks, pin 1 enabled, level1=1, irq enable
        bus_write(4'd1, 8'h07);
        bus_write(4'd0, 8'h05);
        peek_cnt(c);
        write_cmp(0, c + 16'd2);
        ext_tick();
        peek(4'd2, d);
        check(d[0] == 1'b0, "R5 no early flag", d[0], 0);
        check(cmp_pin[0] == 1'b0, "R6 pin before match", cmp_pin[0], 0);
        ext_tick();
        peek_cnt(dd);
        check(dd == c + 16'd2, "R4 one step per edge", dd, c + 16'd2);
        peek(4'd2, d);
        check(d[0] == 1'b1, "R5 flag at match", d[0], 1);
        check(cmp_pin[0] == 1'b1, "R6 pin takes level", cmp_pin[0], 1);
        check(irq == 1'b1, "R7 irq raised", irq, 1);
        irq_mask = 1'b1;
        #1 check(irq == 1'b0, "R7 masked", irq, 0);
        irq_mask = 1'b0;

        // R8: clear handshake
        bus_read(4'd4, d);
        peek(4'd2, d);
        check(d[0] == 1'b1, "R8 low access alone", d[0], 1);
        bus_read(4'd2, d);
        check(d[0] == 1'b1, "R8 status read value", d[0], 1);
        peek(4'd2, d);
        check(d[0] == 1'b1, "R8 status read alone", d[0], 1);
        bus_read(4'd4, d);
        peek(4'd2, d);
        check(d[0] == 1'b0, "R8 cleared", d[0], 0);
        check(irq == 1'b0, "R7 irq drops", irq, 0);

        // R6: channel 2 match with pin disabled
        bus_write(4'd0, 8'h07);
        peek_cnt(c);
        write_cmp(1, c + 16'd1);
        ext_tick();
        peek(4'd2, d);
        check(d[1] == 1'b1, "R5 channel 2 flag", d[1], 1);
        check(cmp_pin[1] == 1'b0, "R6 disabled pin held", cmp_pin[1], 0);

        // R9: high write alone holds compares off
        peek_cnt(c);
        dd = c + 16'd1;
        write_cmp(0, {dd[15:8] ^ 8'h5A, dd[7:0]});
        bus_write(4'd3, dd[15:8]);
        bus_read(4'd3, d);
        check(d == dd[15:8], "R2 high byte readback", d, dd[15:8]);
        ext_tick();
        peek(4'd2, d);
        check(d[0] == 1'b0, "R9 inhibited", d[0], 0);
        dd = c + 16'd2;
        write_cmp(0, dd);
        ext_tick();
        peek(4'd2, d);
        check(d[0] == 1'b1, "R9 re-enabled by low write", d[0], 1);

        // R10: match coincides with the clearing low-byte read
        peek_cnt(c);
        write_cmp(0, c + 16'd1);
        bus_read(4'd2, d);
        @(negedge clk) ext_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 4'd4; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        peek(4'd2, d);
        check(d[0] == 1'b1, "R10 set wins", d[0], 1);
        peek_cnt(dd);
        check(dd == c + 16'd1, "R4 counter after coincident tick", dd, c + 16'd1);

        // R1: reset after activity
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(4'd3, d);
        check(d == 8'h80, "R1 compare high after reset", d, 8'h80);
        peek(4'd2, d);
        check(d == 8'h00, "R1 status after reset", d, 0);
        check(cmp_pin == 2'b00, "R1 pins after reset", cmp_pin, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule